// File: doc/BRIEF.md
# Debug Register Readback Sequencer

This block lets a debug host stream the contents of a halted core's general-purpose register file out through one byte-wide data port. The host talks to it through a simple memory-mapped byte bus. It first writes a mode code to a control byte that turns the multifunction byte into a transfer counter. Next it loads that counter with the number of registers it wants. Last it pulses an execute strobe. While the core is halted, the sequencer walks the register file upward from r0 and queues one register per cycle into a small FIFO. It decrements the counter for each register it queues. The host drains the FIFO by reading its data address over and over.

When the last register has been queued, the sequencer drops back to idle and clears the mode byte. A read of the FIFO address while the FIFO is empty returns zero and raises a sticky underflow bit, which the host clears by writing a one to it. The register file is an input array port that the block reads combinationally. The serial transport that carries the host's bus cycles is outside the block.

Top module: `regrd_seq`

## Requirements
- R1: After reset, the mode byte (address 0x0A) and the counter byte (address 0x00) read 0x00, and the status byte (address 0x0D) reads 0x04 (FIFO empty only).
- R2: While the sequencer is idle, a bus write to 0x0A or 0x00 stores the byte. A bus read of either address returns the stored value on busRdData in the cycle after the read strobe. A read of any unmapped address returns 0x00.
- R3: An execute strobe starts a transfer only if the mode byte equals 0x11, the counter is nonzero, the core is halted and the sequencer is idle. In every other case the strobe leaves state and status unchanged.
- R4: An execute strobe given while coreHalted is low is ignored: the sequencer stays idle and the counter keeps its value.
- R5: During a transfer, registers are queued in ascending index order starting at r0, one per clock cycle. No register is queued while the FIFO is full, and none is lost or skipped.
- R6: The counter decrements by exactly one for each register queued. It can be read back at 0x00 at any time.
- R7: When the counter reaches zero, the sequencer returns to idle and the mode byte reads 0x00.
- R8: Each bus read of 0x0C on a non-empty FIFO returns the oldest queued byte and removes it.
- R9: A bus read of 0x0C on an empty FIFO returns 0x00 and sets status bit 0 (underflow). The bit stays set until a bus write to 0x0D with data bit 0 set clears it.
- R10: Bus writes to 0x0A and 0x00 are ignored while a transfer is running.
- R11: The status byte holds underflow in bit 0, busy in bit 1, FIFO empty in bit 2 and FIFO full in bit 3. Bits 7 to 4 read zero.
- R12: While coreHalted is low during a transfer, queuing pauses. The counter and the register index keep their values, and queuing resumes when the core halts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe, one cycle per write |
| busRdEn | input | 1 | Bus read strobe, one cycle per read |
| busAddr | input | ADDR_W (8) | Bus byte address |
| busWrData | input | DATA_W (8) | Bus write data |
| busRdData | output | DATA_W (8) | Registered read data, valid the cycle after busRdEn |
| execStrobe | input | 1 | Debug execute request, one-cycle pulse |
| coreHalted | input | 1 | High while the core is halted |
| rfData | input | NUM_REGS x DATA_W (32 x 8) | Register file contents, index 0 is r0 |

## Verification
Read data is registered, so the result of any read strobe driven before a rising edge is sampled at the following falling edge. The bench samples exactly there. After an execute strobe that passes the start conditions, the sequencer is busy from the next edge. The first register enters the FIFO one edge after that, and one more enters at each following edge until the FIFO is full or the count is used up. For a transfer of n registers, mode and counter therefore read zero after n+1 edges. The bench waits at least that long before reading them. Full and stalled states are checked only after enough idle cycles for four pushes. Each read in the walk consumes exactly one cycle, so the expected FIFO order and the pause behaviour follow from cycle counting alone.

// File: rtl/regrd_pkg.sv
package regrd_pkg;

  // bus map of the sequencer
  localparam int ADDR_COUNT  = 'h00;
  localparam int ADDR_MODE   = 'h0A;
  localparam int ADDR_FIFO   = 'h0C;
  localparam int ADDR_STATUS = 'h0D;

  // mode code that turns the multifunction byte into a read counter
  localparam int MODE_READ = 'h11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_COUNT,
    SEL_FIFO,
    SEL_STATUS
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   busy;
    logic   loadMode;
    logic   loadCount;
    logic   clearMode;
    logic   restartIdx;
    logic   push;
    logic   pop;
    logic   readEmpty;
    logic   clearUflow;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/regrd_fifo.sv
module regrd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [LVL_W-1:0] level;

  generate
    if (POW2) begin : g_wrap_free
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap_cmp
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign head  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push && !full) wrPtr <= wrNext;
      if (pop && !empty) rdPtr <= rdNext;
      case ({push && !full, pop && !empty})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/regrd_ctrl.sv
module regrd_ctrl
  import regrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              execStrobe,
  input  logic              coreHalted,
  input  logic              modeIsRead,
  input  logic              countZero,
  input  logic              countOne,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output ctlStrobes_t       ctl
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e state, stateNext;
  logic   isIdle, startOk;

  assign isIdle  = (state == ST_IDLE);
  assign startOk = isIdle && execStrobe && coreHalted && modeIsRead && !countZero;

  always_comb begin
    ctl       = '0;
    ctl.rdSel = SEL_NONE;
    ctl.busy  = !isIdle;
    stateNext = state;

    // host writes
    if (busWrEn) begin
      if (busAddr == ADDR_W'(ADDR_MODE) && isIdle)  ctl.loadMode   = 1'b1;
      if (busAddr == ADDR_W'(ADDR_COUNT) && isIdle) ctl.loadCount  = 1'b1;
      if (busAddr == ADDR_W'(ADDR_STATUS) && busWrData[0]) ctl.clearUflow = 1'b1;
    end

    // host reads
    if (busRdEn) begin
      if (busAddr == ADDR_W'(ADDR_MODE)) begin
        ctl.rdSel = SEL_MODE;
      end else if (busAddr == ADDR_W'(ADDR_COUNT)) begin
        ctl.rdSel = SEL_COUNT;
      end else if (busAddr == ADDR_W'(ADDR_FIFO)) begin
        ctl.rdSel = SEL_FIFO;
        if (fifoEmpty) ctl.readEmpty = 1'b1;
        else           ctl.pop       = 1'b1;
      end else if (busAddr == ADDR_W'(ADDR_STATUS)) begin
        ctl.rdSel = SEL_STATUS;
      end
    end

    // sequencing
    case (state)
      ST_IDLE: begin
        if (startOk) begin
          ctl.restartIdx = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (coreHalted && !fifoFull) begin
          ctl.push = 1'b1;
          if (countOne) begin
            ctl.clearMode = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/regrd_dpath.sv
module regrd_dpath
  import regrd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobes_t                       ctl,
  input  logic [DATA_W-1:0]                 busWrData,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]   rfData,
  output logic [DATA_W-1:0]                 busRdData,
  output logic [DATA_W-1:0]                 modeReg,
  output logic [DATA_W-1:0]                 countReg,
  output logic                              uflow,
  output logic                              modeIsRead,
  output logic                              countZero,
  output logic                              countOne,
  output logic                              fifoFull,
  output logic                              fifoEmpty
);

  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int STAT_W = 4;

  logic [IDX_W-1:0]  idxReg, idxNext;
  logic [DATA_W-1:0] fifoHead, rdNext, statusByte;

  assign modeIsRead = (modeReg == DATA_W'(MODE_READ));
  assign countZero  = (countReg == '0);
  assign countOne   = (countReg == DATA_W'(1));
  assign idxNext    = (idxReg == IDX_W'(NUM_REGS - 1)) ? '0 : idxReg + 1'b1;
  assign statusByte = {{(DATA_W - STAT_W){1'b0}}, fifoFull, fifoEmpty, ctl.busy, uflow};

  regrd_fifo #(
    .WIDTH (DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (ctl.push),
    .pushData (rfData[idxReg]),
    .pop      (ctl.pop),
    .head     (fifoHead),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  always_comb begin
    case (ctl.rdSel)
      SEL_MODE:   rdNext = modeReg;
      SEL_COUNT:  rdNext = countReg;
      SEL_FIFO:   rdNext = fifoEmpty ? '0 : fifoHead;
      SEL_STATUS: rdNext = statusByte;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      countReg  <= '0;
      idxReg    <= '0;
      uflow     <= 1'b0;
      busRdData <= '0;
    end else begin
      busRdData <= rdNext;

      if (ctl.clearMode)     modeReg <= '0;
      else if (ctl.loadMode) modeReg <= busWrData;

      if (ctl.push)           countReg <= countReg - 1'b1;
      else if (ctl.loadCount) countReg <= busWrData;

      if (ctl.restartIdx) idxReg <= '0;
      else if (ctl.push)  idxReg <= idxNext;

      if (ctl.readEmpty)       uflow <= 1'b1;
      else if (ctl.clearUflow) uflow <= 1'b0;
    end
  end

endmodule

// File: rtl/regrd_seq.sv
module regrd_seq
  import regrd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrEn,
  input  logic                            busRdEn,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWrData,
  output logic [DATA_W-1:0]               busRdData,
  input  logic                            execStrobe,
  input  logic                            coreHalted,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] rfData
);

  ctlStrobes_t       ctl;
  logic              modeIsRead, countZero, countOne, fifoFull, fifoEmpty;
  logic              uflow, seqBusy, seqPush;
  logic [DATA_W-1:0] modeReg, countReg;

  assign seqBusy = ctl.busy;
  assign seqPush = ctl.push;

  regrd_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .execStrobe (execStrobe),
    .coreHalted (coreHalted),
    .modeIsRead (modeIsRead),
    .countZero  (countZero),
    .countOne   (countOne),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .ctl        (ctl)
  );

  regrd_dpath #(
    .DATA_W     (DATA_W),
    .NUM_REGS   (NUM_REGS),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busWrData  (busWrData),
    .rfData     (rfData),
    .busRdData  (busRdData),
    .modeReg    (modeReg),
    .countReg   (countReg),
    .uflow      (uflow),
    .modeIsRead (modeIsRead),
    .countZero  (countZero),
    .countOne   (countOne),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty)
  );

endmodule

// File: rtl/regrd_seq_chk.sv
module regrd_seq_chk
  import regrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              execStrobe,
  input logic              coreHalted,
  input logic              seqBusy,
  input logic              seqPush,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              uflow,
  input logic [DATA_W-1:0] modeReg,
  input logic [DATA_W-1:0] countReg
);

  logic emptyRead, uflowClear;
  assign emptyRead  = busRdEn && (busAddr == ADDR_W'(ADDR_FIFO)) && fifoEmpty;
  assign uflowClear = busWrEn && (busAddr == ADDR_W'(ADDR_STATUS)) && busWrData[0];

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    emptyRead |=> (busRdData == '0) && uflow);

  p_uflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (uflow && !uflowClear) |=> uflow);

  p_running_start_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!seqBusy && execStrobe && !coreHalted) |=> !seqBusy);

  p_mode_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqBusy) |-> (modeReg == '0) && (countReg == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    seqPush |-> !fifoFull);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && seqPush) |=> countReg == $past(countReg) - 1'b1);

  p_pause_r12: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !coreHalted) |=> $stable(countReg));

  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !seqPush) |=> $stable(countReg) && $stable(modeReg));

endmodule

bind regrd_seq regrd_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .execStrobe (execStrobe),
  .coreHalted (coreHalted),
  .seqBusy    (seqBusy),
  .seqPush    (seqPush),
  .fifoFull   (fifoFull),
  .fifoEmpty  (fifoEmpty),
  .uflow      (uflow),
  .modeReg    (modeReg),
  .countReg   (countReg)
);

// File: tb/regrd_seq_tb.sv
module regrd_seq_tb;

  localparam int NREG = 32;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_EX = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  function automatic logic [7:0] rfVal(int i);
    return 8'((90 + i * 37) % 256);
  endfunction

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD,   8'h0D, 8'h04,     4'd1},   // R1 status after reset
    '{OP_RD,   8'h0A, 8'h00,     4'd1},   // R1 mode after reset
    '{OP_RD,   8'h00, 8'h00,     4'd1},   // R1 counter after reset
    '{OP_WR,   8'h0A, 8'h11,     4'd2},
    '{OP_WR,   8'h00, 8'h03,     4'd2},
    '{OP_RD,   8'h0A, 8'h11,     4'd2},   // R2 readback
    '{OP_RD,   8'h00, 8'h03,     4'd2},   // R2 readback
    '{OP_EX,   8'h00, 8'h00,     4'd3},   // R3 start
    '{OP_IDLE, 8'h00, 8'h00,     4'd0},
    '{OP_IDLE, 8'h00, 8'h00,     4'd0},
    '{OP_IDLE, 8'h00, 8'h00,     4'd0},
    '{OP_RD,   8'h0A, 8'h00,     4'd7},   // R7 mode cleared
    '{OP_RD,   8'h00, 8'h00,     4'd6},   // R6 counted down
    '{OP_RD,   8'h0D, 8'h00,     4'd11},  // R11 idle, not empty, not full
    '{OP_RD,   8'h0C, rfVal(0),  4'd8},   // R8 oldest first
    '{OP_RD,   8'h0C, rfVal(1),  4'd8},
    '{OP_RD,   8'h0C, rfVal(2),  4'd8},
    '{OP_RD,   8'h0D, 8'h04,     4'd11},  // R11 empty again
    '{OP_RD,   8'h0C, 8'h00,     4'd9},   // R9 empty read
    '{OP_RD,   8'h0D, 8'h05,     4'd9},   // R9 sticky flag
    '{OP_WR,   8'h0D, 8'h01,     4'd9},
    '{OP_RD,   8'h0D, 8'h04,     4'd9}    // R9 cleared
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, execStrobe = 1'b0, coreHalted = 1'b1;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic [7:0] busRdData;
  logic [NREG-1:0][7:0] rfData;

  int nTests = 0;
  int nFails = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  regrd_seq u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .execStrobe (execStrobe),
    .coreHalted (coreHalted),
    .rfData     (rfData)
  );

  initial begin
    for (int i = 0; i < NREG; i++) rfData[i] = rfVal(i);
  end

  task automatic check(string tag, logic [7:0] actual, logic [7:0] expected);
    nTests++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, actual, expected);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [7:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic pulseExec();
    execStrobe = 1'b1;
    @(negedge clk);
    execStrobe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectRead(string tag, logic [7:0] a, logic [7:0] e);
    logic [7:0] d;
    busRead(a, d);
    check(tag, d, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      case (VECS[v].op)
        OP_WR: busWrite(VECS[v].addr, VECS[v].data);
        OP_EX: pulseExec();
        OP_RD: begin
          busRead(VECS[v].addr, got);
          check($sformatf("R%0d row %0d", VECS[v].req, v), got, VECS[v].data);
        end
        default: idle(1);
      endcase
    end

    // R3: zero count blocks the start
    busWrite(8'h0A, 8'h11);
    pulseExec();
    idle(1);
    expectRead("R3 zero count", 8'h0D, 8'h04);

    // R3: wrong mode blocks the start
    busWrite(8'h0A, 8'h10);
    busWrite(8'h00, 8'h02);
    pulseExec();
    idle(1);
    expectRead("R3 wrong mode status", 8'h0D, 8'h04);
    expectRead("R3 wrong mode count", 8'h00, 8'h02);

    // R4: core running blocks the start
    busWrite(8'h0A, 8'h11);
    coreHalted = 1'b0;
    pulseExec();
    idle(2);
    expectRead("R4 status", 8'h0D, 8'h04);
    expectRead("R4 count", 8'h00, 8'h02);
    coreHalted = 1'b1;

    // R5 full stall, R6 count, R10 busy writes, R12 pause
    busWrite(8'h00, 8'h06);
    pulseExec();
    idle(8);
    expectRead("R5 full and busy", 8'h0D, 8'h0A);
    expectRead("R6 count after four", 8'h00, 8'h02);
    busWrite(8'h0A, 8'h00);
    expectRead("R10 mode write", 8'h0A, 8'h11);
    busWrite(8'h00, 8'h09);
    expectRead("R10 count write", 8'h00, 8'h02);
    coreHalted = 1'b0;
    expectRead("R8 first pop", 8'h0C, rfVal(0));
    idle(3);
    expectRead("R12 paused count", 8'h00, 8'h02);
    expectRead("R12 busy not full", 8'h0D, 8'h02);
    coreHalted = 1'b1;
    idle(4);
    for (int k = 1; k < 6; k++) expectRead($sformatf("R5 order r%0d", k), 8'h0C, rfVal(k));
    expectRead("R7 mode after run", 8'h0A, 8'h00);
    expectRead("R11 idle empty", 8'h0D, 8'h04);
    expectRead("R2 unmapped", 8'h3F, 8'h00);

    // R1: reset in mid-run
    busWrite(8'h0A, 8'h11);
    busWrite(8'h00, 8'h05);
    pulseExec();
    idle(2);
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    idle(1);
    expectRead("R1 status after reset", 8'h0D, 8'h04);
    expectRead("R1 count after reset", 8'h00, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule